// File: doc/BRIEF.md
# Parallel SAR ADC Conversion Controller

This block starts conversions on a 16-bit successive-approximation converter with a parallel output bus, and collects the result of each one. A single-cycle `start` request is accepted only while `ready` is high. The block first drives the read/convert line low. After a programmed setup interval it drives chip-select low as well. After a short hold it releases both lines together, early in the conversion, so that their edges do not disturb the sampled value.

The converter's busy flag passes through a two-flop synchronizer. The block waits for busy to go low and then for it to return high. On the clock after the synchronized rising edge is seen, it captures the two's-complement data bus and pulses `valid`. The captured word is also presented in two other forms: offset binary, which is the same word with its MSB inverted, and a sign-extended copy on a wider bus.

Two watchdogs abort a transaction and pulse `timeout`. The first fires if busy never goes low after chip-select is asserted. The second fires if busy stays low longer than a maximum conversion time. All intervals are parameters in clock cycles. An elaboration-time check rejects a setup time under 100 ns, a hold time over 200 ns, or a total low time on read/convert over 3.3 µs for the stated clock period.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After a `start` accepted at a clock edge, `rc_n` is low and `cs_n` high for exactly SETUP_CYC cycles, and then `cs_n` falls while `rc_n` is still low.
- R2: `cs_n` stays low for exactly HOLD_CYC cycles with `rc_n` low throughout, and then both lines return high on the same cycle.
- R3: `valid` is a one-cycle pulse that appears 4 clock edges after `busy` rises. At that point `result` equals the `dbus` value presented with the rising edge, and `result` does not change while `valid` is low.
- R4: `result_ob` equals `result` with bit 15 inverted: 0x7FFF→0xFFFF, 0x0000→0x8000, 0xFFFF→0x7FFF, 0x8000→0x0000.
- R5: `result_sx` (EXT_W bits) holds `result` in its low 16 bits, and every bit above them is a copy of bit 15.
- R6: `ready` is high only while the block is idle, with both lines high. A `start` while `ready` is low is ignored and drives neither line low.
- R7: If `busy` is still high FALL_TMO cycles after `cs_n` first goes low, `timeout` pulses at exactly that cycle, no `valid` follows, and `ready` returns.
- R8: If `busy` stays low for CONV_TMO cycles, `timeout` pulses, no `valid` is produced for that conversion, and the next conversion works normally. `valid` and `timeout` are never high together.
- R9: During and just after reset, `rc_n` = `cs_n` = 1, `ready` = 1, `valid` = `timeout` = 0 and `result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, sampled while ready |
| busy | input | 1 | Converter busy flag, low during conversion (asynchronous) |
| dbus | input | 16 | Converter parallel data, two's complement |
| rc_n | output | 1 | Read/convert line, active low |
| cs_n | output | 1 | Chip-select line, active low |
| ready | output | 1 | A new start will be accepted |
| valid | output | 1 | One-cycle strobe: new result captured |
| timeout | output | 1 | One-cycle strobe: transaction aborted |
| result | output | 16 | Captured two's-complement word |
| result_ob | output | 16 | Captured word in offset binary |
| result_sx | output | EXT_W | Captured word sign-extended |

## Verification
The line outputs are decoded from state, so `rc_n` is low at the first falling clock edge after the accepting edge. The bench measures the setup and hold intervals by counting falling edges until each line changes, and compares the counts with SETUP_CYC and HOLD_CYC. The bench raises `busy` at a falling edge and expects `valid` at the fourth falling edge after it: two synchronizer stages, one state step and one capture register. The bench checks for `valid` to be low at the edges before that one. The fall watchdog must fire at exactly FALL_TMO falling edges after the first low sample of `cs_n`. The conversion watchdog is checked over a window that ends before `busy` is released.

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl #(
  parameter int T_CLK_NS  = 10,
  parameter int SETUP_CYC = 10,
  parameter int HOLD_CYC  = 4,
  parameter int FALL_TMO  = 32,
  parameter int CONV_TMO  = 200,
  parameter int DW        = 16,
  parameter int EXT_W     = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic [DW-1:0]    dbus,
  output logic             rc_n,
  output logic             cs_n,
  output logic             ready,
  output logic             valid,
  output logic             timeout,
  output logic [DW-1:0]    result,
  output logic [DW-1:0]    result_ob,
  output logic [EXT_W-1:0] result_sx
);
  localparam int MAXC = (CONV_TMO > FALL_TMO) ? ((CONV_TMO > SETUP_CYC) ? CONV_TMO : SETUP_CYC)
                                              : ((FALL_TMO > SETUP_CYC) ? FALL_TMO : SETUP_CYC);
  localparam int CW = $clog2(MAXC + 1);

  initial begin
    assert (SETUP_CYC * T_CLK_NS >= 100) else $error("setup interval below 100 ns");
    assert (HOLD_CYC >= 1 && HOLD_CYC * T_CLK_NS <= 200) else $error("hold interval above 200 ns");
    assert ((SETUP_CYC + HOLD_CYC) * T_CLK_NS <= 3300) else $error("start pulse above 3.3 us");
    assert (FALL_TMO > HOLD_CYC) else $error("fall window shorter than hold");
    assert (EXT_W > DW) else $error("extended width must exceed data width");
  end

  typedef enum logic [2:0] {IDLE, SETUP, STROBE, WFALL, WRISE, CAPT} st_t;
  st_t           st;
  logic [CW-1:0] cnt;
  logic          b_s1, b_s2;

  assign rc_n      = !(st == SETUP || st == STROBE);
  assign cs_n      = (st != STROBE);
  assign ready     = (st == IDLE);
  assign result_ob = {~result[DW-1], result[DW-2:0]};
  assign result_sx = {{(EXT_W-DW){result[DW-1]}}, result};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_s1 <= 1'b1;
      b_s2 <= 1'b1;
    end else begin
      b_s1 <= busy;
      b_s2 <= b_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      valid   <= 1'b0;
      timeout <= 1'b0;
      result  <= '0;
    end else begin
      valid   <= 1'b0;
      timeout <= 1'b0;
      cnt     <= cnt + 1'b1;
      case (st)
        IDLE: begin
          cnt <= '0;
          if (start) st <= SETUP;
        end
        SETUP:
          if (cnt == CW'(SETUP_CYC - 1)) begin
            st  <= STROBE;
            cnt <= '0;
          end
        STROBE:
          if (cnt == CW'(HOLD_CYC - 1)) st <= WFALL;
        WFALL:
          if (!b_s2) begin
            st  <= WRISE;
            cnt <= '0;
          end else if (cnt == CW'(FALL_TMO - 1)) begin
            st      <= IDLE;
            timeout <= 1'b1;
          end
        WRISE:
          if (b_s2) st <= CAPT;
          else if (cnt == CW'(CONV_TMO - 1)) begin
            st      <= IDLE;
            timeout <= 1'b1;
          end
        CAPT: begin
          result <= dbus;
          valid  <= 1'b1;
          st     <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  AST_RC_LEADS_CS:   assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> !$past(rc_n)); // R1
  AST_CS_UNDER_RC:   assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> !rc_n); // R2
  AST_JOINT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> rc_n); // R2
  AST_VALID_ONE:     assert property (@(posedge clk) disable iff (!rst_n) valid |=> !valid); // R3
  AST_RESULT_HELD:   assert property (@(posedge clk) disable iff (!rst_n) !valid |-> $stable(result)); // R3
  AST_IDLE_LINES:    assert property (@(posedge clk) disable iff (!rst_n) ready |-> (rc_n && cs_n)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (!ready && rc_n) |=> rc_n); // R6
  AST_NO_BOTH:       assert property (@(posedge clk) disable iff (!rst_n) !(valid && timeout)); // R8
endmodule

// File: tb/sar_conv_ctrl_test.sv
`timescale 1ns/1ps
module sar_conv_ctrl_test;
  localparam int SETUP_CYC = 10;
  localparam int HOLD_CYC  = 4;
  localparam int FALL_TMO  = 32;
  localparam int CONV_TMO  = 200;
  localparam int EXT_W     = 24;

  logic clk = 0, rst_n = 0, start = 0, busy = 1;
  logic [15:0] dbus = '0;
  logic rc_n, cs_n, ready, valid, timeout;
  logic [15:0] result, result_ob;
  logic [EXT_W-1:0] result_sx;
  int nchk = 0, nfail = 0;
  bit done = 0;

  sar_conv_ctrl #(.T_CLK_NS(10), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
                  .FALL_TMO(FALL_TMO), .CONV_TMO(CONV_TMO), .DW(16), .EXT_W(EXT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .dbus(dbus),
    .rc_n(rc_n), .cs_n(cs_n), .ready(ready), .valid(valid), .timeout(timeout),
    .result(result), .result_ob(result_ob), .result_sx(result_sx));

  always #5 clk = ~clk;

  function automatic logic [15:0] exp_ob(input logic [15:0] v);
    return v ^ 16'h8000;
  endfunction
  function automatic logic [EXT_W-1:0] exp_sx(input logic [15:0] v);
    return v[15] ? {{(EXT_W-16){1'b1}}, v} : {{(EXT_W-16){1'b0}}, v};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic convert(input logic [15:0] val, input int conv_cyc, input bit no_fall, input bit poke);
    int n;
    bit saw_to, saw_val, saw_rc;
    @(negedge clk);
    chk(ready, "R6", "ready before start", ready, 1);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(!rc_n && cs_n, "R1", "rc_n low first", {rc_n, cs_n}, 2'b01);
    n = 0;
    while (cs_n && n < 1000) begin n++; @(negedge clk); end
    chk(n == SETUP_CYC, "R1", "setup cycles", n, SETUP_CYC);
    chk(!rc_n, "R1", "rc_n low at cs fall", rc_n, 0);
    if (!no_fall) busy = 0;
    n = 0;
    while (!cs_n && n < 1000) begin
      if (rc_n) chk(0, "R2", "rc_n rose during strobe", rc_n, 0);
      n++; @(negedge clk);
    end
    chk(n == HOLD_CYC, "R2", "hold cycles", n, HOLD_CYC);
    chk(rc_n && cs_n, "R2", "joint release", {rc_n, cs_n}, 2'b11);
    if (no_fall) begin
      while (!timeout && n < FALL_TMO + 10) begin @(negedge clk); n++; end
      chk(n == FALL_TMO, "R7", "fall timeout cycle", n, FALL_TMO);
      chk(!valid, "R7", "no valid on fall timeout", valid, 0);
      @(negedge clk);
      chk(ready && !valid, "R7", "ready after fall timeout", {ready, valid}, 2'b10);
      return;
    end
    saw_to = 0; saw_val = 0; saw_rc = 0;
    for (int i = 0; i < conv_cyc; i++) begin
      @(negedge clk);
      start = (poke && i < 2);
      if (timeout) saw_to = 1;
      if (valid) saw_val = 1;
      if (!rc_n) saw_rc = 1;
      if (poke && i < 2) chk(!ready, "R6", "ready low in conversion", ready, 0);
    end
    start = 0;
    if (poke) chk(!saw_rc, "R6", "start ignored while converting", saw_rc, 0);
    if (conv_cyc > CONV_TMO) begin
      chk(saw_to, "R8", "conversion timeout seen", saw_to, 1);
      chk(!saw_val, "R8", "no valid on conversion timeout", saw_val, 0);
      chk(ready, "R8", "ready after conversion timeout", ready, 1);
      busy = 1;
      repeat (4) @(negedge clk);
      return;
    end
    chk(!saw_to, "R8", "no spurious timeout", saw_to, 0);
    dbus = val; busy = 1;
    n = 0;
    while (!valid && n < 20) begin @(negedge clk); n++; end
    chk(n == 4, "R3", "valid latency", n, 4);
    chk(result == val, "R3", "result", result, val);
    chk(result_ob == exp_ob(val), "R4", "offset binary", result_ob, exp_ob(val));
    chk(result_sx == exp_sx(val), "R5", "sign extension", result_sx, exp_sx(val));
    chk(ready, "R6", "ready with valid", ready, 1);
    @(negedge clk);
    chk(!valid, "R3", "valid single cycle", valid, 0);
    dbus = ~val;
    repeat (2) @(negedge clk);
    chk(result == val, "R3", "result held", result, val);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(rc_n && cs_n && ready && !valid && !timeout && result == 0, "R9", "reset state",
        {rc_n, cs_n, ready, valid, timeout}, 5'b11100);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rc_n && cs_n && ready && result == 0, "R9", "after reset", {rc_n, cs_n, ready}, 3'b111);
    convert(16'h7FFF, 20, 0, 0);
    convert(16'h0000, 20, 0, 0);
    convert(16'hFFFF, 20, 0, 0);
    convert(16'h8000, 20, 0, 1);
    convert(16'h1234, 0, 1, 0);
    convert(16'h5555, CONV_TMO + 20, 0, 0);
    convert(16'hA5A5, 30, 0, 0);
    for (int k = 0; k < 24; k++)
      convert(16'($urandom), 5 + int'($urandom % 56), 0, (k % 5) == 0);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule